// File: doc/BRIEF.md
# Single-Precision Compare with Condition Codes

This block compares two IEEE-754 single-precision operands and evaluates one of sixteen predicates on the pair. It produces a one-bit verdict and an invalid-operation flag. The verdict is also placed into a condition/branch control word, ready to be written back at control index 1. Fetching operands from a register file and handling traps are left to the surrounding logic.

Requests arrive on a valid/ready channel. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the output channel one cycle later with `out_valid` set. The result is retired on an edge where `out_valid` and `out_ready` are both high. While the result is not taken, the output holds and `in_ready` stays low. When the consumer takes a result, a new request is accepted on the same edge. A downstream reader must not sample the control word until `out_valid` has risen for its compare.

Code bits [2:0] form a mask of three relations: bit 0 is unordered, bit 1 is equal and bit 2 is less. The verdict is the OR of the selected relations, so code 0 is always false and code 7 means "not greater". Code bit 3 chooses which NaNs raise the invalid flag: quiet and signalling NaNs when it is set, signalling NaNs only when it is clear.

Top module: `fcmp_cc`

## Requirements
- R1: After reset, `out_valid`, `out_res`, `out_invalid` and `out_cbr` are 0 and `in_ready` is 1.
- R2: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. The unordered relation is true exactly when either operand is a NaN. When it is true, the less and equal relations are false.
- R3: `out_res` is the OR of the relations selected by code bits [2:0]: bit 0 selects unordered, bit 1 selects equal and bit 2 selects less. Infinities and normal values are ordered by their numeric value.
- R4: Codes 0 and 8 give `out_res` = 0 for every operand pair.
- R5: Positive zero and negative zero compare equal, and neither is less than the other.
- R6: Denormal operands are compared by their exact value, with no flush to zero.
- R7: For codes 0 to 7, `out_invalid` is 1 exactly when either operand is a signalling NaN, which is a NaN whose fraction bit 22 is 0.
- R8: For codes 8 to 15, `out_invalid` is 1 exactly when either operand is a NaN of either kind.
- R9: A request accepted on a clock edge produces `out_valid` = 1 with its result after that same edge, one cycle later. `out_valid` falls after an edge where the result is taken and no new request is accepted.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold their values. `in_ready` is 1 whenever `out_valid` = 0 or `out_ready` = 1.
- R11: While `out_valid` = 1, bit `CBR_RES_POS` of `out_cbr` equals `out_res` and every other bit of `out_cbr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can accept a request |
| in_op_a | input | 32 | Left operand (single precision) |
| in_op_b | input | 32 | Right operand (single precision) |
| in_code | input | 4 | Condition code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 1 | Predicate verdict |
| out_cbr | output | 32 | Condition/branch control word carrying the verdict |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The checker watches the handshake on every cycle. It checks that each accepted request is followed by a valid result, that a stalled result holds with `in_ready` low, and that the control word carries only the verdict bit. On every accepted request it also checks that codes 0 and 8 give a false verdict, that identical non-NaN operands satisfy the equal code, and that any NaN raises the invalid flag under codes 8 to 15. Other behaviour can only be shown by the bench's sweep: the full predicate table, zero and denormal ordering, and the split between quiet and signalling NaNs. The bench runs every pair from a set of boundary operands under all sixteen codes and compares each result with a value it computes from its own numeric model.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CODE_W = 4;

  // Per-operand classification
  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_zero;
  } fp_class_t;

  // Relations between the two operands (greater is implied when none is set)
  typedef struct packed {
    logic lt;
    logic eq;
    logic unord;
  } fp_rel_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output fp_class_t    cls,
  output logic [W-2:0] mag
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  always_comb begin
    exp_f       = op[W-2:FRAC_W];
    frac_f      = op[FRAC_W-1:0];
    exp_ones    = &exp_f;
    frac_nz     = |frac_f;
    cls.sign    = op[W-1];
    cls.is_nan  = exp_ones & frac_nz;
    // Quiet bit is the top fraction bit; clear means signalling
    cls.is_snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls.is_zero = ~|op[W-2:0];
    mag         = op[W-2:0];
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 31
) (
  input  fp_class_t        cls_a,
  input  fp_class_t        cls_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  output fp_rel_t          rel
);
  logic unord;
  logic both_zero;
  logic mag_lt;
  logic mag_gt;
  logic mag_eq;
  logic lt_raw;

  always_comb begin
    unord     = cls_a.is_nan | cls_b.is_nan;
    both_zero = cls_a.is_zero & cls_b.is_zero;
    // Sign-magnitude bit patterns order like unsigned integers per sign
    mag_lt    = mag_a < mag_b;
    mag_gt    = mag_a > mag_b;
    mag_eq    = mag_a == mag_b;
    unique case ({cls_a.sign, cls_b.sign})
      2'b00:   lt_raw = mag_lt;
      2'b11:   lt_raw = mag_gt;
      2'b10:   lt_raw = 1'b1;
      default: lt_raw = 1'b0;
    endcase
    rel.unord = unord;
    rel.eq    = ~unord & (both_zero | ((cls_a.sign == cls_b.sign) & mag_eq));
    rel.lt    = ~unord & ~both_zero & lt_raw;
  end
endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  fp_rel_t           rel,
  input  fp_class_t         cls_a,
  input  fp_class_t         cls_b,
  output logic              res,
  output logic              invalid
);
  localparam int NREL = 3;
  logic [NREL-1:0] rel_vec;
  logic [NREL-1:0] hit;

  assign rel_vec = {rel.lt, rel.eq, rel.unord};

  // Each low code bit enables one relation
  for (genvar i = 0; i < NREL; i++) begin : g_sel
    assign hit[i] = code[i] & rel_vec[i];
  end

  always_comb begin
    res = |hit;
    if (code[CODE_W-1])
      invalid = cls_a.is_nan | cls_b.is_nan;
    else
      invalid = cls_a.is_snan | cls_b.is_snan;
  end
endmodule

// File: rtl/fcmp_cc.sv
module fcmp_cc
  import fcmp_pkg::*;
#(
  parameter int EXP_W       = 8,
  parameter int FRAC_W      = 23,
  parameter int CBR_W       = 32,
  parameter int CBR_RES_POS = 0,
  localparam int W          = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_op_a,
  input  logic [W-1:0]      in_op_b,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_res,
  output logic [CBR_W-1:0]  out_cbr,
  output logic              out_invalid
);
  localparam int NOPS  = 2;
  localparam int MAG_W = W - 1;

  logic [W-1:0]     ops  [NOPS];
  fp_class_t        cls  [NOPS];
  logic [MAG_W-1:0] mags [NOPS];
  fp_rel_t          rel;
  logic             res_d;
  logic             inv_d;
  logic             accept;

  assign ops[0] = in_op_a;
  assign ops[1] = in_op_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) cls_i (
      .op (ops[k]),
      .cls(cls[k]),
      .mag(mags[k])
    );
  end

  fcmp_order #(.MAG_W(MAG_W)) ord_i (
    .cls_a(cls[0]),
    .cls_b(cls[1]),
    .mag_a(mags[0]),
    .mag_b(mags[1]),
    .rel  (rel)
  );

  fcmp_predicate pred_i (
    .code   (in_code),
    .rel    (rel),
    .cls_a  (cls[0]),
    .cls_b  (cls[1]),
    .res    (res_d),
    .invalid(inv_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_res     <= 1'b0;
      out_invalid <= 1'b0;
      out_cbr     <= '0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_res     <= res_d;
      out_invalid <= inv_d;
      out_cbr     <= CBR_W'(res_d) << CBR_RES_POS;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/fcmp_cc_chk.sv
module fcmp_cc_chk #(
  parameter int EXP_W       = 8,
  parameter int FRAC_W      = 23,
  parameter int CBR_W       = 32,
  parameter int CBR_RES_POS = 0,
  localparam int W          = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [W-1:0]     in_op_a,
  input logic [W-1:0]     in_op_b,
  input logic [3:0]       in_code,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_res,
  input logic [CBR_W-1:0] out_cbr,
  input logic             out_invalid
);
  logic acc;
  logic a_nan;
  logic b_nan;
  assign acc   = in_valid & in_ready;
  assign a_nan = (&in_op_a[W-2:FRAC_W]) & (|in_op_a[FRAC_W-1:0]);
  assign b_nan = (&in_op_b[W-2:FRAC_W]) & (|in_op_b[FRAC_W-1:0]);

  AST_ACCEPT_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_invalid) && $stable(out_cbr))); // R10
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_FALSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_code[2:0] == 3'd0) |=> !out_res); // R4
  AST_SELF_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op_a == in_op_b && !a_nan && in_code[2:0] == 3'd2) |=> out_res); // R3
  AST_ANY_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_code[3] && (a_nan || b_nan)) |=> out_invalid); // R8
  AST_CBR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cbr[CBR_RES_POS] == out_res && $countones(out_cbr) == {31'd0, out_res})); // R11
endmodule

bind fcmp_cc fcmp_cc_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .CBR_W(CBR_W), .CBR_RES_POS(CBR_RES_POS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op_a(in_op_a), .in_op_b(in_op_b), .in_code(in_code),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .out_cbr(out_cbr), .out_invalid(out_invalid)
);

// File: tb/fcmp_cc_tb_top.sv
module fcmp_cc_tb_top;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_op_a = '0;
  logic [31:0] in_op_b = '0;
  logic [3:0]  in_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_res;
  logic [31:0] out_cbr;
  logic        out_invalid;

  int total = 0;
  int bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  fcmp_cc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op_a(in_op_a), .in_op_b(in_op_b), .in_code(in_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
    .out_cbr(out_cbr), .out_invalid(out_invalid)
  );

  // Operand set: bits, numeric value, nan and signalling flags
  logic [31:0] vbits [NV];
  real         vval  [NV];
  bit          vnan  [NV];
  bit          vsnan [NV];

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    in_op_a  = a;
    in_op_b  = b;
    in_code  = c;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    vbits[0]  = 32'h0000_0000; vval[0]  = 0.0;
    vbits[1]  = 32'h8000_0000; vval[1]  = 0.0;
    vbits[2]  = 32'h0000_0001; vval[2]  = 1.0e-45;
    vbits[3]  = 32'h0000_0002; vval[3]  = 2.0e-45;
    vbits[4]  = 32'h8000_0001; vval[4]  = -1.0e-45;
    vbits[5]  = 32'h3F80_0000; vval[5]  = 1.0;
    vbits[6]  = 32'hBF80_0000; vval[6]  = -1.0;
    vbits[7]  = 32'h4000_0000; vval[7]  = 2.0;
    vbits[8]  = 32'h7F80_0000; vval[8]  = 1.0e300;
    vbits[9]  = 32'hFF80_0000; vval[9]  = -1.0e300;
    vbits[10] = 32'h7FC0_0000; vval[10] = 0.0;
    vbits[11] = 32'h7F80_0001; vval[11] = 0.0;
    vbits[12] = 32'hFFC0_0000; vval[12] = 0.0;
    for (int i = 0; i < NV; i++) begin
      vnan[i]  = (i >= 10);
      vsnan[i] = (i == 11);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
    check("R1", "in_ready", {31'd0, in_ready}, 32'd1);
    check("R1", "out_res", {31'd0, out_res}, 32'd0);
    check("R1", "out_invalid", {31'd0, out_invalid}, 32'd0);
    check("R1", "out_cbr", out_cbr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep every pair under every code
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        for (int c = 0; c < 16; c++) begin
          bit un, eq, lt, er, ei;
          string tag;
          string itag;
          un = vnan[i] || vnan[j];
          eq = !un && (vval[i] == vval[j]);
          lt = !un && (vval[i] < vval[j]);
          er = (c[0] && un) || (c[1] && eq) || (c[2] && lt);
          ei = c[3] ? un : (vsnan[i] || vsnan[j]);
          if ((c & 7) == 0)                         tag = "R4";
          else if (un)                              tag = "R2";
          else if (i <= 1 && j <= 1)                tag = "R5";
          else if ((i >= 2 && i <= 4) || (j >= 2 && j <= 4)) tag = "R6";
          else                                      tag = "R3";
          itag = c[3] ? "R8" : "R7";
          send(vbits[i], vbits[j], 4'(c));
          check("R9", "out_valid", {31'd0, out_valid}, 32'd1);
          check(tag, "out_res", {31'd0, out_res}, {31'd0, er});
          check(itag, "out_invalid", {31'd0, out_invalid}, {31'd0, ei});
          check("R11", "out_cbr", out_cbr, {31'd0, er});
        end
      end
    end
    @(negedge clk);
    check("R9", "out_valid after take", {31'd0, out_valid}, 32'd0);

    // R10 back-pressure
    out_ready = 1'b0;
    send(vbits[5], vbits[7], 4'd4);           // 1 < 2 : true
    check("R10", "result under stall", {31'd0, out_res}, 32'd1);
    in_op_a = vbits[7]; in_op_b = vbits[5]; in_code = 4'd4; in_valid = 1'b1; // 2 < 1 : false
    #1;
    check("R10", "in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "held result", {31'd0, out_res}, 32'd1);
    check("R10", "held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    #1;
    check("R10", "in_ready with out_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R10", "second result", {31'd0, out_res}, 32'd0);
    check("R10", "second valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R9", "drained", {31'd0, out_valid}, 32'd0);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end
endmodule